// File: doc/BRIEF.md
# Calibrating SAR Section Sequencer

This block sequences one slice of a time-interleaved successive-approximation converter. After a phase-start pulse it runs a fixed frame of sixteen clock cycles, over and over, until reset. The first three cycles are for calibration: a reference-zero sample, then an offset compare, then a gain compare. The fourth cycle samples the analog input. The next eleven cycles run a binary search, one bit per cycle, and the last cycle hands the finished word on. The analog parts (comparator, trial DAC and track-and-hold) sit outside the block. The block drives them with step strobes and a trial code, and reads back a single comparator decision each cycle.

The offset and gain compare results are kept in their own registers. Each one is announced by a one-cycle flag, so an external correction loop can use it. The result word appears with a one-cycle valid strobe and stays unchanged until the next frame's transfer. Sixteen of these sections, each started one cycle after the previous one, give one sample per clock.

Top module: `sar_slice_seq`

## Requirements
- R1: While `rst_n` is low, all outputs are zero: every step strobe, `dac_code`, `result`, `result_vld`, `az_bit`, `az_vld`, `cal_bit` and `cal_vld`. Reset takes effect without waiting for a clock edge.
- R2: After reset the section is idle and all step strobes stay low until `frame_start` is seen high at a rising edge. The cycle after that edge is cycle 1. A `frame_start` pulse that arrives while a frame is running has no effect.
- R3: A frame is 16 cycles, and frames repeat back to back. `refz_smp` is high in cycle 1, `az_cmp` in cycle 2, `cal_cmp` in cycle 3, `in_smp` in cycle 4 and `result_vld` in cycle 16. No two of these are high in the same cycle.
- R4: The value of `cmp_ge` at the end of cycle 2 appears on `az_bit` in cycle 3. In that cycle `az_vld` is high for exactly one clock. `az_bit` then holds until the next cycle-2 capture.
- R5: The value of `cmp_ge` at the end of cycle 3 appears on `cal_bit` in cycle 4. In that cycle `cal_vld` is high for exactly one clock. `cal_bit` then holds until the next cycle-3 capture.
- R6: In cycle 5+k (k = 0..10), `dac_code` is the bits kept so far with bit 10-k set. The search goes MSB first. A `cmp_ge` of 1 at the end of the cycle keeps that bit, and a 0 clears it. Outside cycles 5..15, `dac_code` is zero.
- R7: In cycle 16, `result` holds the 11 decided bits and `result_vld` is high for exactly one clock. If the comparator reports (target >= trial), `result` equals the target.
- R8: Whenever `result_vld` is low, `result` is unchanged from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all frame events advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Phase-start pulse; starts the first frame when idle |
| cmp_ge | input | 1 | Comparator decision: input at or above the trial level |
| refz_smp | output | 1 | Cycle 1: sample the reference zero |
| az_cmp | output | 1 | Cycle 2: offset (auto-zero) compare |
| cal_cmp | output | 1 | Cycle 3: gain (auto-calibrate) compare |
| in_smp | output | 1 | Cycle 4: sample the analog input |
| dac_code | output | 11 | Trial code during the search, zero otherwise |
| az_bit | output | 1 | Captured offset compare result |
| az_vld | output | 1 | One-cycle flag marking a new `az_bit` |
| cal_bit | output | 1 | Captured gain compare result |
| cal_vld | output | 1 | One-cycle flag marking a new `cal_bit` |
| result | output | 11 | Converted word |
| result_vld | output | 1 | One-cycle transfer strobe in cycle 16 |

## Verification
On every cycle, the assertions check that the step strobes are exclusive and come in the right order. They also check that the frame wraps from transfer back to reference-zero sampling, and that the calibration flags and the result strobe last one cycle. Both captured bits and the result must hold between updates, and the trial code must start at the MSB and stay zero outside the search. The bench scenarios are needed for the rest. They show that the captured bits match the comparator values the bench drove, and that each trial code follows the keep-or-clear decisions. They show that the final word equals the analog target at the range ends and in the middle. They also cover three timing cases: the section stays idle with no start pulse, a start pulse during a running frame is ignored, and a reset mid-frame returns the section to idle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Step of the conversion frame currently in progress.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REFZ,
    PH_AZERO,
    PH_ACAL,
    PH_TRACK,
    PH_SEARCH,
    PH_XFER
  } phase_e;

  // Cycles in front of the search: reference zero, offset, gain, sample.
  localparam int unsigned PRE_SLOTS = 4;

  function automatic int unsigned frame_len(input int unsigned nbits);
    return nbits + PRE_SLOTS + 1;
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
  import sar_seq_pkg::*;
#(
  parameter int unsigned SAR_BITS = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  output phase_e                      phase_o,
  output logic [$clog2(SAR_BITS)-1:0] step_o
);
  localparam int unsigned FRAME_LEN = frame_len(SAR_BITS);
  localparam int unsigned SLOT_W    = $clog2(FRAME_LEN);
  localparam int unsigned STEP_W    = $clog2(SAR_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] SRCH_LO   = SLOT_W'(PRE_SLOTS);

  logic              active_q, active_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;
  logic [SLOT_W-1:0] step_full;

  // Next state: leave idle only on start, then wrap forever.
  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        slot_d   = '0;
      end
    end else if (slot_q == LAST_SLOT) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  assign slot_en = active_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      active_q <= active_d;
      if (slot_en) slot_q <= slot_d;
    end
  end

  // Decode the slot into the frame step.
  always_comb begin
    if (!active_q)                        phase_o = PH_IDLE;
    else if (slot_q == SLOT_W'(0))        phase_o = PH_REFZ;
    else if (slot_q == SLOT_W'(1))        phase_o = PH_AZERO;
    else if (slot_q == SLOT_W'(2))        phase_o = PH_ACAL;
    else if (slot_q == SLOT_W'(3))        phase_o = PH_TRACK;
    else if (slot_q == LAST_SLOT)         phase_o = PH_XFER;
    else                                  phase_o = PH_SEARCH;
  end

  assign step_full = slot_q - SRCH_LO;
  assign step_o    = step_full[STEP_W-1:0];
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg
  import sar_seq_pkg::*;
#(
  parameter int unsigned SAR_BITS = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  phase_e                      phase_i,
  input  logic [$clog2(SAR_BITS)-1:0] step_i,
  input  logic                        cmp_i,
  output logic [SAR_BITS-1:0]         dac_o,
  output logic [SAR_BITS-1:0]         result_o,
  output logic                        done_o
);
  localparam int unsigned STEP_W = $clog2(SAR_BITS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SAR_BITS - 1);

  logic                srch, clr;
  logic [SAR_BITS-1:0] mask, trial, decided;
  logic [SAR_BITS-1:0] work_q, work_d;
  logic                work_en;
  logic                res_en;

  assign srch = (phase_i == PH_SEARCH);
  assign clr  = (phase_i == PH_TRACK);

  // Bit under trial: step 0 is the MSB.
  for (genvar i = 0; i < SAR_BITS; i++) begin : g_mask
    assign mask[i] = srch && (step_i == STEP_W'(SAR_BITS - 1 - i));
  end

  assign trial   = work_q | mask;
  assign decided = cmp_i ? trial : work_q;

  always_comb begin
    work_d = work_q;
    if (clr)       work_d = '0;
    else if (srch) work_d = decided;
  end

  assign work_en = clr | srch;
  assign res_en  = srch && (step_i == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q   <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (work_en) work_q <= work_d;
      if (res_en)  result_o <= decided;
      done_o <= res_en;
    end
  end

  assign dac_o = srch ? trial : '0;
endmodule

// File: rtl/sar_cal_tap.sv
module sar_cal_tap (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o,
  output logic vld_o
);
  logic bit_d;

  always_comb bit_d = en_i ? bit_i : bit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      bit_o <= bit_d;
      vld_o <= en_i;
    end
  end
endmodule

// File: rtl/sar_slice_seq.sv
module sar_slice_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned SAR_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                cmp_ge,
  output logic                refz_smp,
  output logic                az_cmp,
  output logic                cal_cmp,
  output logic                in_smp,
  output logic [SAR_BITS-1:0] dac_code,
  output logic                az_bit,
  output logic                az_vld,
  output logic                cal_bit,
  output logic                cal_vld,
  output logic [SAR_BITS-1:0] result,
  output logic                result_vld
);
  localparam int unsigned STEP_W = $clog2(SAR_BITS);
  localparam int unsigned N_TAPS = 2;

  logic              rst_i_n;
  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [N_TAPS-1:0] tap_en, tap_bit, tap_vld;

  sar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sar_frame_timer #(.SAR_BITS(SAR_BITS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start_i (frame_start),
    .phase_o (phase),
    .step_o  (step)
  );

  sar_search_reg #(.SAR_BITS(SAR_BITS)) u_search (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .phase_i  (phase),
    .step_i   (step),
    .cmp_i    (cmp_ge),
    .dac_o    (dac_code),
    .result_o (result),
    .done_o   (result_vld)
  );

  // Tap 0 captures the offset compare, tap 1 the gain compare.
  assign tap_en = {phase == PH_ACAL, phase == PH_AZERO};

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    sar_cal_tap u_tap (
      .clk   (clk),
      .rst_n (rst_i_n),
      .en_i  (tap_en[t]),
      .bit_i (cmp_ge),
      .bit_o (tap_bit[t]),
      .vld_o (tap_vld[t])
    );
  end

  assign az_bit  = tap_bit[0];
  assign az_vld  = tap_vld[0];
  assign cal_bit = tap_bit[1];
  assign cal_vld = tap_vld[1];

  assign refz_smp = (phase == PH_REFZ);
  assign az_cmp   = tap_en[0];
  assign cal_cmp  = tap_en[1];
  assign in_smp   = (phase == PH_TRACK);
endmodule

// File: rtl/sar_slice_seq_chk.sv
module sar_slice_seq_chk #(
  parameter int unsigned SAR_BITS = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                refz_smp,
  input logic                az_cmp,
  input logic                cal_cmp,
  input logic                in_smp,
  input logic [SAR_BITS-1:0] dac_code,
  input logic                az_bit,
  input logic                az_vld,
  input logic                cal_bit,
  input logic                cal_vld,
  input logic [SAR_BITS-1:0] result,
  input logic                result_vld
);
  localparam logic [SAR_BITS-1:0] MSB_TRIAL = {1'b1, {(SAR_BITS-1){1'b0}}};

  // R1: reset clears everything without a clock
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!refz_smp && !az_cmp && !cal_cmp && !in_smp
                                   && dac_code == '0 && result == '0 && !result_vld
                                   && !az_vld && !cal_vld && !az_bit && !cal_bit);
    end
  end

  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refz_smp, az_cmp, cal_cmp, in_smp, result_vld}));
  a_r3_refz_then_az: assert property (@(posedge clk) disable iff (!rst_n)
    refz_smp |=> az_cmp);
  a_r3_az_then_cal: assert property (@(posedge clk) disable iff (!rst_n)
    az_cmp |=> cal_cmp);
  a_r3_cal_then_smp: assert property (@(posedge clk) disable iff (!rst_n)
    cal_cmp |=> in_smp);
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> refz_smp);

  a_r4_az_flag: assert property (@(posedge clk) disable iff (!rst_n)
    az_cmp |=> az_vld);
  a_r4_az_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    az_vld |=> !az_vld);
  a_r4_az_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !az_vld |-> $stable(az_bit));

  a_r5_cal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cal_cmp |=> cal_vld);
  a_r5_cal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cal_vld |=> !cal_vld);
  a_r5_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_vld |-> $stable(cal_bit));

  a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    in_smp |=> (dac_code == MSB_TRIAL));
  a_r6_quiet_dac: assert property (@(posedge clk) disable iff (!rst_n)
    (refz_smp || az_cmp || cal_cmp || in_smp || result_vld) |-> (dac_code == '0));

  a_r7_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld |-> $stable(result));
endmodule

bind sar_slice_seq sar_slice_seq_chk #(.SAR_BITS(SAR_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .refz_smp   (refz_smp),
  .az_cmp     (az_cmp),
  .cal_cmp    (cal_cmp),
  .in_smp     (in_smp),
  .dac_code   (dac_code),
  .az_bit     (az_bit),
  .az_vld     (az_vld),
  .cal_bit    (cal_bit),
  .cal_vld    (cal_vld),
  .result     (result),
  .result_vld (result_vld)
);

// File: tb/sar_slice_seq_test.sv
module sar_slice_seq_test;
  localparam int NB = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start;
  logic          cmp_ge;
  logic          refz_smp, az_cmp, cal_cmp, in_smp;
  logic [NB-1:0] dac_code, result;
  logic          az_bit, az_vld, cal_bit, cal_vld, result_vld;

  logic [NB-1:0] tgt;
  logic          use_model, force_bit;
  logic [NB-1:0] prev_res;
  int            n_cmp = 0;
  int            n_bad = 0;
  int            cyc = 0;
  bit            done = 0;

  always #2 clk = ~clk;  // 250 MHz

  // Behavioural comparator: input at or above the trial level.
  assign cmp_ge = use_model ? (tgt >= dac_code) : force_bit;

  sar_slice_seq #(.SAR_BITS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmp_ge(cmp_ge),
    .refz_smp(refz_smp), .az_cmp(az_cmp), .cal_cmp(cal_cmp), .in_smp(in_smp),
    .dac_code(dac_code), .az_bit(az_bit), .az_vld(az_vld), .cal_bit(cal_bit),
    .cal_vld(cal_vld), .result(result), .result_vld(result_vld)
  );

  function automatic int steps();
    return {refz_smp, az_cmp, cal_cmp, in_smp, result_vld};
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic step_clk();
    @(posedge clk); #1;
  endtask

  task automatic kick();
    @(negedge clk) frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
  endtask

  task automatic check_idle(input int n);
    for (int i = 0; i < n; i++) begin
      chk_eq("R2 idle steps", steps(), 0);
      chk_eq("R2 idle dac", int'(dac_code), 0);
      step_clk();
    end
  endtask

  task automatic check_zero(input string req);
    chk_eq(req, steps(), 0);
    chk_eq(req, int'(dac_code), 0);
    chk_eq(req, int'(result), 0);
    chk_eq(req, {az_vld, cal_vld, az_bit, cal_bit}, 0);
  endtask

  // Entered in cycle 1; leaves in cycle 1 of the next frame.
  task automatic run_frame(input logic [NB-1:0] t, input bit azb, input bit calb,
                           input bit poke);
    logic [NB-1:0] kept;
    logic [NB-1:0] trial;
    kept = '0;
    for (int s = 0; s < 16; s++) begin
      if (s != 15) chk_eq("R8 result held", int'(result), int'(prev_res));
      case (s)
        0: begin
          chk_eq("R3 cycle1 refz", steps(), 5'b10000);
          chk_eq("R6 dac idle", int'(dac_code), 0);
        end
        1: begin
          chk_eq("R3 cycle2 az", steps(), 5'b01000);
          use_model = 1'b0;
          force_bit = azb;
        end
        2: begin
          chk_eq("R3 cycle3 cal", steps(), 5'b00100);
          chk_eq("R4 az_vld", int'(az_vld), 1);
          chk_eq("R4 az_bit", int'(az_bit), int'(azb));
          force_bit = calb;
        end
        3: begin
          chk_eq("R3 cycle4 smp", steps(), 5'b00010);
          chk_eq("R4 az_vld one cycle", int'(az_vld), 0);
          chk_eq("R5 cal_vld", int'(cal_vld), 1);
          chk_eq("R5 cal_bit", int'(cal_bit), int'(calb));
          tgt = t;
          use_model = 1'b1;
        end
        15: begin
          chk_eq("R7 cycle16 xfer", steps(), 5'b00001);
          chk_eq("R7 result", int'(result), int'(t));
          chk_eq("R6 dac after search", int'(dac_code), 0);
          chk_eq("R4 az_bit hold", int'(az_bit), int'(azb));
          chk_eq("R5 cal_bit hold", int'(cal_bit), int'(calb));
          prev_res = t;
          use_model = 1'b0;
        end
        default: begin
          trial = kept | (NB'(1) << (14 - s));
          chk_eq("R6 trial code", int'(dac_code), int'(trial));
          chk_eq("R3 search quiet", steps(), 0);
          if (t >= trial) kept = trial;
          if (poke && s == 7) frame_start = 1'b1;
          if (s == 8) frame_start = 1'b0;
        end
      endcase
      step_clk();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7855));
    rst_n = 1'b0; frame_start = 1'b0; use_model = 1'b0; force_bit = 1'b0;
    tgt = '0; prev_res = '0;
    repeat (3) @(posedge clk);
    #1 check_zero("R1 reset state");
    frame_start = 1'b1;  // start during reset does nothing
    step_clk();
    check_zero("R1 start in reset");
    frame_start = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    step_clk();
    check_idle(8);

    kick();
    run_frame(11'd0,    1'b0, 1'b1, 1'b0);
    run_frame(11'd2047, 1'b1, 1'b0, 1'b0);
    run_frame(11'd1024, 1'b1, 1'b1, 1'b1);
    run_frame(11'd1023, 1'b0, 1'b0, 1'b0);
    run_frame(11'd1,    1'b1, 1'b0, 1'b1);
    run_frame(11'd2046, 1'b0, 1'b1, 1'b0);
    for (int f = 0; f < 40; f++) begin
      run_frame(NB'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // Reset in the middle of a search: asynchronous clear, then idle.
    repeat (6) step_clk();
    rst_n = 1'b0;
    #1 check_zero("R1 async reset mid-frame");
    repeat (3) step_clk();
    check_zero("R1 held reset");
    @(negedge clk) rst_n = 1'b1;
    step_clk();
    prev_res = '0;
    check_idle(10);

    kick();
    run_frame(11'd512, 1'b1, 1'b1, 1'b1);
    for (int f = 0; f < 4; f++) begin
      run_frame(NB'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule